// File: doc/BRIEF.md
# Two-Bank Hashed Recent-Tag Table

This block remembers recently seen cache-line tags in two small direct-mapped banks. The left bank takes tags from the demand path. The right bank takes tags from the prefetch-fill path. A query port reports in the same cycle whether a tag is held in either bank, and also which bank holds it. An offset-learning prefetcher uses it in this way: it asks whether the line one candidate offset behind the current access was touched recently.

Each bank places a tag at a slot picked by its own hash. For bank `w` (left is 0, right is 1), `h1 = tag >> w` and `h2 = h1 >> log2(ENTRIES)`. The slot is the low `log2(ENTRIES)` bits of `h1 ^ h2`. A write always overwrites its slot, and nothing else ever evicts an entry. The caller decides which tags go to which bank. For example, the caller writes the fill tag minus the active offset, and only for prefetch fills while prefetching is on. `ENTRIES` must be a power of two, and elaboration stops with an error otherwise.

Top module: `recent_req_table`

## Requirements
- R1: After reset every slot in both banks is invalid, so no query hits, including a query for tag 0.
- R2: A left write puts its tag in left slot `((t) ^ (t >> log2(ENTRIES)))` masked to `log2(ENTRIES)` bits. With the defaults (12-bit tags, 16 slots), tags that differ only in bits 11..8 share a left slot.
- R3: A right write puts its tag in right slot `((t >> 1) ^ (t >> (1 + log2(ENTRIES))))` masked to `log2(ENTRIES)` bits. With the defaults, tags that differ only in bit 0 or in bits 11..9 share a right slot.
- R4: A left write replaces the tag in its slot. The earlier tag at that slot then misses in the left bank, and the new tag hits.
- R5: A right write replaces the tag in its slot in the same way, and leaves the left bank untouched.
- R6: `q_hit_left` and `q_hit_right` report a match in the left and right bank. `q_hit` is high when either one is high.
- R7: A query sees the table as it stood before any write in the same cycle. A tag written at one clock edge hits from the next cycle on.
- R8: A left write and a right write in the same cycle both take effect.
- R9: A write tag presented while its enable is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid bits |
| wl_en | input | 1 | Write the left (demand) bank |
| wl_tag | input | TAG_W | Tag for the left bank |
| wr_en | input | 1 | Write the right (prefetch-fill) bank |
| wr_tag | input | TAG_W | Tag for the right bank |
| q_tag | input | TAG_W | Tag to look up |
| q_hit_left | output | 1 | Tag present in the left bank |
| q_hit_right | output | 1 | Tag present in the right bank |
| q_hit | output | 1 | Tag present in either bank |

## Verification
The assertions assume that the tag inputs are never unknown in a cycle where the query or a write matters. They also assume that reset is released away from a clock edge. The bench drives every input with defined values on the falling edge, including reset release. Random tags come from a masked pool, so that slot collisions occur often in both banks. Directed sequences cover the aliasing pairs named in R2 and R3, same-cycle read-before-write, and dual-bank writes.

// File: rtl/recent_req_table.sv
module recent_req_table #(
  parameter int TAG_W   = 12,
  parameter int ENTRIES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wl_en,
  input  logic [TAG_W-1:0] wl_tag,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TAG_W-1:0] q_tag,
  output logic             q_hit_left,
  output logic             q_hit_right,
  output logic             q_hit
);
  localparam int IDX_W = $clog2(ENTRIES);

  if ((1 << IDX_W) != ENTRIES) begin : g_bad_entries
    $error("ENTRIES must be a power of two");
  end

  function automatic logic [IDX_W-1:0] slot_of(input logic [TAG_W-1:0] t, input int w);
    logic [TAG_W-1:0] h1, mix;
    h1  = t >> w;
    mix = h1 ^ (h1 >> IDX_W);
    return mix[IDX_W-1:0];
  endfunction

  logic [1:0] bank_hit;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic             we;
    logic [TAG_W-1:0] wt;
    logic [IDX_W-1:0] wslot, qslot;
    logic [TAG_W-1:0] tags [ENTRIES];
    logic [ENTRIES-1:0] vld;

    assign we    = (b == 0) ? wl_en  : wr_en;
    assign wt    = (b == 0) ? wl_tag : wr_tag;
    assign wslot = slot_of(wt, b);
    assign qslot = slot_of(q_tag, b);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)  vld <= '0;
      else if (we) vld[wslot] <= 1'b1;

    always_ff @(posedge clk)
      if (we) tags[wslot] <= wt;

    assign bank_hit[b] = vld[qslot] && (tags[qslot] == q_tag);
  end

  assign q_hit_left  = bank_hit[0];
  assign q_hit_right = bank_hit[1];
  assign q_hit       = |bank_hit;

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !q_hit);

  a_r4_left_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |=> (q_tag != $past(wl_tag)) || q_hit_left);

  a_r5_right_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q_tag != $past(wr_tag)) || q_hit_right);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wl_en) && !$past(wr_en) && $stable(q_tag)) |-> $stable({q_hit_left, q_hit_right}));

  a_r6_any_bank: assert property (@(posedge clk) disable iff (!rst_n)
    q_hit |-> (q_hit_left || q_hit_right));
endmodule

// File: tb/test_recent_req_table.sv
`timescale 1ns/1ps
module test_recent_req_table;
  localparam int TW = 12;
  localparam int NE = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wl_en = 1'b0, wr_en = 1'b0;
  logic [TW-1:0] wl_tag = '0, wr_tag = '0, q_tag = '0;
  logic q_hit_left, q_hit_right, q_hit;

  int total = 0, bad = 0;

  logic [TW-1:0] m_tag [2][NE];
  bit           m_vld [2][NE];

  always #2 clk = ~clk;

  recent_req_table #(.TAG_W(TW), .ENTRIES(NE)) i_recent_req_table (
    .clk(clk), .rst_n(rst_n),
    .wl_en(wl_en), .wl_tag(wl_tag),
    .wr_en(wr_en), .wr_tag(wr_tag),
    .q_tag(q_tag),
    .q_hit_left(q_hit_left), .q_hit_right(q_hit_right), .q_hit(q_hit));

  function automatic int hidx(input logic [TW-1:0] t, input int w);
    int v;
    v = (int'(t) >> w) ^ (int'(t) >> (w + 4));
    return v & (NE - 1);
  endfunction

  function automatic bit model_hit(input logic [TW-1:0] t, input int w);
    int s;
    s = hidx(t, w);
    return m_vld[w][s] && (m_tag[w][s] == t);
  endfunction

  task automatic step(input bit le, input logic [TW-1:0] lt, input bit re,
                      input logic [TW-1:0] rt, input logic [TW-1:0] q, input string req);
    bit el, er;
    wl_en = le; wl_tag = lt; wr_en = re; wr_tag = rt; q_tag = q;
    #1;
    el = model_hit(q, 0);
    er = model_hit(q, 1);
    total++;
    if ({q_hit_left, q_hit_right, q_hit} !== {el, er, el | er}) begin
      bad++;
      $display("FAIL %s tag=%h got l/r/any=%b%b%b exp=%b%b%b", req, q,
               q_hit_left, q_hit_right, q_hit, el, er, el | er);
    end
    if (le) begin m_tag[0][hidx(lt, 0)] = lt; m_vld[0][hidx(lt, 0)] = 1'b1; end
    if (re) begin m_tag[1][hidx(rt, 1)] = rt; m_vld[1][hidx(rt, 1)] = 1'b1; end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < 2; w++)
      for (int i = 0; i < NE; i++) begin m_vld[w][i] = 1'b0; m_tag[w][i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty table after reset
    step(0, 0, 0, 0, 12'h000, "R1");
    step(0, 0, 0, 0, 12'h5A3, "R1");
    // R7: same-cycle lookup sees old state, next cycle sees new
    step(1, 12'h123, 0, 0, 12'h123, "R7");
    step(0, 0, 0, 0, 12'h123, "R7");
    // R2/R4: left aliasing via bits 11..8
    step(1, 12'h035, 0, 0, 12'h035, "R2");
    step(1, 12'h135, 0, 0, 12'h035, "R4");
    step(0, 0, 0, 0, 12'h035, "R4");
    step(0, 0, 0, 0, 12'h135, "R2");
    // R3/R5: right aliasing via bit 0, left untouched
    step(0, 0, 1, 12'h0A6, 12'h0A6, "R3");
    step(0, 0, 1, 12'h0A7, 12'h0A6, "R5");
    step(0, 0, 0, 0, 12'h0A6, "R5");
    step(0, 0, 0, 0, 12'h0A7, "R3");
    step(0, 0, 0, 0, 12'h135, "R5");
    // R8: both banks in one cycle
    step(1, 12'h777, 1, 12'h4C2, 12'h000, "R8");
    step(0, 0, 0, 0, 12'h777, "R8");
    step(0, 0, 0, 0, 12'h4C2, "R8");
    // R6: right-only and both-bank hits
    step(0, 0, 1, 12'h777, 12'h4C2, "R6");
    step(0, 0, 0, 0, 12'h777, "R6");
    // R9: disabled writes leave table alone
    step(0, 12'h835, 0, 12'h4C3, 12'h777, "R9");
    step(0, 0, 0, 0, 12'h835, "R9");
    step(0, 0, 0, 0, 12'h4C2, "R9");
    // random traffic with a collision-heavy tag pool
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [TW-1:0] a, b, c;
      bit ea, eb;
      a  = TW'($urandom) & 12'hE1F;
      b  = TW'($urandom) & 12'hE1F;
      c  = ($urandom % 3 == 0) ? a : (TW'($urandom) & 12'hE1F);
      ea = ($urandom % 3) != 0;
      eb = ($urandom % 3) != 0;
      step(ea, a, eb, b, c, "R6");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule